// File: doc/BRIEF.md
# Gate Fault Monitor and Response

This block watches the gate drive of a set of half-bridges. Each half-bridge has a high-side and a low-side gate command. Each gate has a digital comparator flag that goes high once the gate-source voltage has crossed its threshold. A per-gate timer measures how long a command has been active without that flag. When the time exceeds the drive window, a gate fault is declared. The block then acts according to a two-bit response setting: it can hold the shutdown until cleared, release it on the next PWM activity, only warn, or ignore the fault entirely.

The shutdown is carried out through per-bridge pull-down enables. In the bridge arrangements where each half-bridge is driven on its own, the shutdown can be limited to the half-bridge that faulted. A pin-strapped variant fixes the behaviour: cycle-by-cycle response, a window of 4 µs and per-bridge shutdown. A separate strap can turn protection off. All ports are plain control and status levels, so no data stream and no valid/ready handshake is involved.

Top module: `gate_fault_mon`

## Requirements
- R1: Gate g belongs to half-bridge g/2; even g is the high side and odd g the low side. A gate times out once its command has been sampled high, with its comparator flag low, on TDRIVE consecutive clock edges. The response appears at the outputs one edge later. A low command or a high comparator flag restarts the count from zero.
- R2: The window is TDRIVE_CYC cycles when strap_sel is 0, and CLK_MHZ*4 cycles when strap_sel is 1.
- R3: resp_mode 00 is latched. A fault sets pd_en for the targeted bridges, raises fault_flag, drives nfault low and sets vgs_flag of the faulting bridge. PWM edges do not release any of these.
- R4: resp_mode 01 is cycle-by-cycle. A fault acts as in R3, but a rising or falling edge on pwm_in[b] clears pd_en[b] on the edge it is sampled. vgs_flag stays set. A new fault in the same cycle wins over the release.
- R5: resp_mode 10 is warning-only. A fault sets warn_flag and the vgs_flag of the faulting bridge. pd_en, fault_flag and nfault are unchanged.
- R6: resp_mode 11 is disabled. Gate faults set no output.
- R7: When bridge_mode is 00 or 11 and per-bridge shutdown is on, only the faulting half-bridge gets pd_en. In all other cases every half-bridge gets it.
- R8: With strap_sel at 1, resp_mode and ind_shdn are ignored. The response is cycle-by-cycle and per-bridge shutdown is on. If strap_off is also 1, the response is disabled.
- R9: A clr_flt pulse clears pd_en, warn_flag and vgs_flag only when no gate is timed out at that moment. Otherwise the pulse has no effect.
- R10: After reset, pd_en and all flags are 0 and nfault is 1. fault_flag is 1 exactly when any pd_en bit is 1, and nfault is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_cmd | input | 2*NB | Gate commands, index 2b high side, 2b+1 low side |
| vgs_ok | input | 2*NB | Comparator flags, gate-source threshold crossed |
| pwm_in | input | NB | PWM input per half-bridge |
| bridge_mode | input | 2 | Bridge arrangement; 00 and 11 permit per-bridge shutdown |
| resp_mode | input | 2 | 00 latched, 01 cycle-by-cycle, 10 warning-only, 11 disabled |
| ind_shdn | input | 1 | Per-bridge shutdown select |
| strap_sel | input | 1 | Selects the pin-strapped variant |
| strap_off | input | 1 | Strap level that disables protection |
| clr_flt | input | 1 | Clear-fault strobe |
| pd_en | output | NB | Gate pull-down enable per half-bridge |
| nfault | output | 1 | Active-low fault pin |
| fault_flag | output | 1 | Fault status bit |
| warn_flag | output | 1 | Warning status bit, sticky |
| vgs_flag | output | NB | Per-bridge sticky gate-fault bit |

## Verification
The bench targets the exact timeout edge. It checks that nothing happens one cycle before the edge. It also checks that the count restarts after the comparator crosses, so a design that kept counting would trip early. It clears a fault while the timed-out command is still active; a design that ignored the still-present condition would drop the latched shutdown. It also releases the two bridges one at a time in cycle-by-cycle mode. This would expose a design that released every bridge together, or one that cleared the sticky bit on a PWM edge. Random trials cover every mode, bridge arrangement and strap combination, so a wrong shutdown scope shows up as the wrong pd_en mask.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  typedef enum logic [1:0] {
    RESP_LATCH = 2'b00,
    RESP_CBC   = 2'b01,
    RESP_WARN  = 2'b10,
    RESP_OFF   = 2'b11
  } resp_e;

  localparam logic [1:0] BRG_SPLIT_A = 2'b00;
  localparam logic [1:0] BRG_SPLIT_B = 2'b11;
endpackage

// File: rtl/gfm_policy.sv
module gfm_policy
  import gfm_pkg::*;
(
  input  logic [1:0] resp_mode,
  input  logic [1:0] bridge_mode,
  input  logic       ind_shdn,
  input  logic       strap_sel,
  input  logic       strap_off,
  output resp_e      eff_mode,
  output logic       indep
);
  logic split_ok;

  always_comb begin
    if (strap_sel) begin
      eff_mode = strap_off ? RESP_OFF : RESP_CBC;
    end else begin
      eff_mode = resp_e'(resp_mode);
    end
  end

  assign split_ok = (bridge_mode == BRG_SPLIT_A) || (bridge_mode == BRG_SPLIT_B);
  assign indep    = split_ok && (strap_sel || ind_shdn);
endmodule

// File: rtl/gfm_gate_timer.sv
module gfm_gate_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cmd,
  input  logic          ok,
  input  logic [CW-1:0] limit,
  output logic          timeout
);
  logic [CW-1:0] cnt;

  // Count consecutive edges with the command high and the comparator low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || !cmd || ok) begin
      cnt <= '0;
    end else if (cnt < limit) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign timeout = (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/gfm_bridge_resp.sv
module gfm_bridge_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_req,
  input  logic hit,
  input  logic pwm_edge,
  input  logic cbc,
  input  logic clr_ok,
  output logic pd_en,
  output logic vgs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_en <= 1'b0;
    end else if (shut_req) begin
      pd_en <= 1'b1;
    end else if (clr_ok) begin
      pd_en <= 1'b0;
    end else if (cbc && pwm_edge) begin
      pd_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vgs <= 1'b0;
    end else if (hit) begin
      vgs <= 1'b1;
    end else if (clr_ok) begin
      vgs <= 1'b0;
    end
  end
endmodule

// File: rtl/gate_fault_mon.sv
module gate_fault_mon
  import gfm_pkg::*;
#(
  parameter int NB         = 2,
  parameter int TDRIVE_CYC = 32,
  parameter int CLK_MHZ    = 100,
  parameter int STRAP_US   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NB-1:0] gate_cmd,
  input  logic [2*NB-1:0] vgs_ok,
  input  logic [NB-1:0]   pwm_in,
  input  logic [1:0]      bridge_mode,
  input  logic [1:0]      resp_mode,
  input  logic            ind_shdn,
  input  logic            strap_sel,
  input  logic            strap_off,
  input  logic            clr_flt,
  output logic [NB-1:0]   pd_en,
  output logic            nfault,
  output logic            fault_flag,
  output logic            warn_flag,
  output logic [NB-1:0]   vgs_flag
);
  localparam int NG        = 2 * NB;
  localparam int STRAP_CYC = CLK_MHZ * STRAP_US;
  localparam int MAXC      = (STRAP_CYC > TDRIVE_CYC) ? STRAP_CYC : TDRIVE_CYC;
  localparam int CW        = $clog2(MAXC + 1);

  resp_e          eff_mode;
  logic           indep;
  logic           mon_en;
  logic [CW-1:0]  limit;
  logic [NG-1:0]  timeout;
  logic [NG-1:0]  timeout_q;
  logic [NG-1:0]  ev;
  logic [NB-1:0]  hit;
  logic [NB-1:0]  shut_req;
  logic [NB-1:0]  pwm_q;
  logic [NB-1:0]  pwm_edge;
  logic           any_hit;
  logic           any_cond;
  logic           clr_ok;
  logic           shut_mode;

  gfm_policy u_policy (
    .resp_mode   (resp_mode),
    .bridge_mode (bridge_mode),
    .ind_shdn    (ind_shdn),
    .strap_sel   (strap_sel),
    .strap_off   (strap_off),
    .eff_mode    (eff_mode),
    .indep       (indep)
  );

  assign mon_en = (eff_mode != RESP_OFF);
  assign limit  = strap_sel ? CW'(STRAP_CYC) : CW'(TDRIVE_CYC);

  for (genvar g = 0; g < NG; g++) begin : g_timer
    gfm_gate_timer #(.CW(CW)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mon_en),
      .cmd     (gate_cmd[g]),
      .ok      (vgs_ok[g]),
      .limit   (limit),
      .timeout (timeout[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q <= '0;
      pwm_q     <= '0;
    end else begin
      timeout_q <= timeout;
      pwm_q     <= pwm_in;
    end
  end

  assign ev        = timeout & ~timeout_q;
  assign pwm_edge  = pwm_in ^ pwm_q;
  assign any_hit   = |hit;
  assign any_cond  = |timeout;
  assign clr_ok    = clr_flt && !any_cond;
  assign shut_mode = (eff_mode == RESP_LATCH) || (eff_mode == RESP_CBC);

  for (genvar b = 0; b < NB; b++) begin : g_bridge
    assign hit[b]      = ev[2*b] | ev[2*b+1];
    assign shut_req[b] = shut_mode && (indep ? hit[b] : any_hit);

    gfm_bridge_resp u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .shut_req (shut_req[b]),
      .hit      (hit[b]),
      .pwm_edge (pwm_edge[b]),
      .cbc      (eff_mode == RESP_CBC),
      .clr_ok   (clr_ok),
      .pd_en    (pd_en[b]),
      .vgs      (vgs_flag[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_flag <= 1'b0;
    end else if ((eff_mode == RESP_WARN) && any_hit) begin
      warn_flag <= 1'b1;
    end else if (clr_ok) begin
      warn_flag <= 1'b0;
    end
  end

  assign fault_flag = |pd_en;
  assign nfault     = ~fault_flag;
endmodule

// File: rtl/gate_fault_mon_chk.sv
module gate_fault_mon_chk #(
  parameter int NB = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2*NB-1:0] gate_cmd,
  input logic [NB-1:0]   pwm_in,
  input logic [1:0]      resp_mode,
  input logic            strap_sel,
  input logic            strap_off,
  input logic            clr_flt,
  input logic [NB-1:0]   pd_en,
  input logic [NB-1:0]   vgs_flag
);
  logic latch_now, cbc_now, warn_now, off_now;

  assign latch_now = !strap_sel && (resp_mode == 2'b00);
  assign cbc_now   = strap_sel ? !strap_off : (resp_mode == 2'b01);
  assign warn_now  = !strap_sel && (resp_mode == 2'b10);
  assign off_now   = strap_sel ? strap_off : (resp_mode == 2'b11);

  // R1: a sticky bit only rises when a gate command was active two edges earlier
  p_vgs_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((vgs_flag & ~$past(vgs_flag)) != '0) |-> ($past(gate_cmd, 2) != '0));

  // R3: in latched mode a shutdown bit is released only after a clear strobe
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_now && $past(latch_now) && !$past(clr_flt)) |-> (($past(pd_en) & ~pd_en) == '0));

  // R4: in cycle-by-cycle mode a bridge is released only by its own PWM edge or a clear
  p_cbc_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_now && $past(cbc_now) && !$past(clr_flt)) |->
      (($past(pd_en) & ~pd_en & ~($past(pwm_in) ^ $past(pwm_in, 2))) == '0));

  // R5: warning-only mode never raises a pull-down enable
  p_warn_no_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_now && $past(warn_now)) |-> ((pd_en & ~$past(pd_en)) == '0));

  // R6: disabled mode never raises a sticky bit
  p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_now && $past(off_now)) |-> ((vgs_flag & ~$past(vgs_flag)) == '0));
endmodule

bind gate_fault_mon gate_fault_mon_chk #(.NB(NB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_cmd  (gate_cmd),
  .pwm_in    (pwm_in),
  .resp_mode (resp_mode),
  .strap_sel (strap_sel),
  .strap_off (strap_off),
  .clr_flt   (clr_flt),
  .pd_en     (pd_en),
  .vgs_flag  (vgs_flag)
);

// File: tb/gate_fault_mon_tb_top.sv
`timescale 1ns/1ps
module gate_fault_mon_tb_top;
  localparam int NB     = 2;
  localparam int NG     = 2 * NB;
  localparam int TD     = 32;
  localparam int STRAPC = 400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG-1:0] gate_cmd = '0;
  logic [NG-1:0] vgs_ok = '0;
  logic [NB-1:0] pwm_in = '0;
  logic [1:0]    bridge_mode = 2'b00;
  logic [1:0]    resp_mode = 2'b00;
  logic          ind_shdn = 1'b0;
  logic          strap_sel = 1'b0;
  logic          strap_off = 1'b0;
  logic          clr_flt = 1'b0;
  logic [NB-1:0] pd_en;
  logic          nfault, fault_flag, warn_flag;
  logic [NB-1:0] vgs_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gate_fault_mon #(.NB(NB), .TDRIVE_CYC(TD), .CLK_MHZ(100), .STRAP_US(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .vgs_ok(vgs_ok), .pwm_in(pwm_in),
    .bridge_mode(bridge_mode), .resp_mode(resp_mode), .ind_shdn(ind_shdn),
    .strap_sel(strap_sel), .strap_off(strap_off), .clr_flt(clr_flt),
    .pd_en(pd_en), .nfault(nfault), .fault_flag(fault_flag),
    .warn_flag(warn_flag), .vgs_flag(vgs_flag)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] eff_of(input logic [1:0] m, input logic s, input logic so);
    if (s) return so ? 2'b11 : 2'b01;
    return m;
  endfunction

  function automatic int lim_of(input logic s);
    return s ? STRAPC : TD;
  endfunction

  function automatic logic [NB-1:0] mask_of(input logic [1:0] eff, input logic [1:0] bm,
                                            input logic ind, input logic s, input int g);
    logic per;
    if (eff == 2'b10 || eff == 2'b11) return '0;
    per = ((bm == 2'b00) || (bm == 2'b11)) && (s || ind);
    if (per) return NB'(1) << (g / 2);
    return '1;
  endfunction

  task automatic full_clear();
    gate_cmd = '0;
    tick(2);
    clr_flt = 1'b1;
    tick(1);
    clr_flt = 1'b0;
  endtask

  task automatic check_outs(input string req, input logic [NB-1:0] pd, input logic [NB-1:0] vg,
                            input logic wr);
    chk({req, " pd_en"}, 8'(pd_en), 8'(pd));
    chk({req, " vgs_flag"}, 8'(vgs_flag), 8'(vg));
    chk({req, " warn_flag"}, 8'(warn_flag), 8'(wr));
    chk({req, " fault_flag"}, 8'(fault_flag), 8'(pd != '0));
    chk({req, " nfault"}, 8'(nfault), 8'(pd == '0));
  endtask

  task automatic trial(input logic [1:0] m, input logic [1:0] bm, input logic ind,
                       input logic s, input logic so, input int g);
    logic [1:0]    eff;
    logic [NB-1:0] msk, vexp;
    int            b, lim;
    eff  = eff_of(m, s, so);
    lim  = lim_of(s);
    msk  = mask_of(eff, bm, ind, s, g);
    b    = g / 2;
    vexp = (eff == 2'b11) ? '0 : (NB'(1) << b);
    resp_mode = m; bridge_mode = bm; ind_shdn = ind; strap_sel = s; strap_off = so;
    vgs_ok = '0;
    full_clear();
    gate_cmd[g] = 1'b1;
    tick(lim);
    check_outs("R1 R2 before window", '0, '0, 1'b0);
    tick(1);
    check_outs("R1 R7 R8 at window", msk, vexp, eff == 2'b10);
    gate_cmd = '0;
    tick(3);
    if (eff == 2'b00) begin
      pwm_in = ~pwm_in;
      tick(2);
      check_outs("R3 pwm ignored", msk, vexp, 1'b0);
    end else if (eff == 2'b01) begin
      pwm_in[b] = ~pwm_in[b];
      tick(1);
      check_outs("R4 own bridge release", msk & ~(NB'(1) << b), vexp, 1'b0);
      pwm_in = ~pwm_in;
      tick(1);
      check_outs("R4 all released", '0, vexp, 1'b0);
    end else if (eff == 2'b10) begin
      check_outs("R5 warning holds", '0, vexp, 1'b1);
    end else begin
      check_outs("R6 silent", '0, '0, 1'b0);
    end
    clr_flt = 1'b1;
    tick(1);
    clr_flt = 1'b0;
    check_outs("R9 cleared", '0, '0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    tick(3);
    check_outs("R10 in reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    tick(2);
    check_outs("R10 after reset", '0, '0, 1'b0);

    // R1: comparator crossing restarts the count
    resp_mode = 2'b00; bridge_mode = 2'b01; ind_shdn = 1'b1;
    gate_cmd[1] = 1'b1;
    tick(TD - 3);
    vgs_ok[1] = 1'b1;
    tick(TD + 5);
    check_outs("R1 crossed in time", '0, '0, 1'b0);
    vgs_ok[1] = 1'b0;
    tick(TD);
    check_outs("R1 restarted count", '0, '0, 1'b0);
    tick(1);
    check_outs("R1 R7 all bridges", 2'b11, 2'b01, 1'b0);

    // R9: clear ignored while the gate is still timed out
    clr_flt = 1'b1;
    tick(1);
    clr_flt = 1'b0;
    check_outs("R9 clear blocked", 2'b11, 2'b01, 1'b0);
    full_clear();
    check_outs("R9 clear accepted", '0, '0, 1'b0);

    // Directed: every mode, split arrangement, per-bridge shutdown on high-side gate 2
    for (int m = 0; m < 4; m++) trial(2'(m), 2'b11, 1'b1, 1'b0, 1'b0, 2);
    // R8: strap variant ignores resp_mode and ind_shdn; strap_off disables
    trial(2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 3);
    trial(2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 0);

    for (int i = 0; i < 28; i++) begin
      logic s;
      s = ($urandom_range(0, 5) == 0);
      trial(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            s, 1'($urandom_range(0, 1)), $urandom_range(0, NG - 1));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule